// File: doc/BRIEF.md
# Compare and Test Flag Generator

This block evaluates a subtraction of a source operand from a destination operand at one of three operand sizes (8, 16 or 32 bits) and reports only the resulting condition flags. The difference itself never leaves the block. A test mode replaces the source with zero, so the flags describe the destination operand on its own. This is how a "compare against zero" is formed.

The block sits beside an execution unit. Each clock it samples the two operands, the size code, the mode and the incoming extend flag. One cycle later it presents a five-bit flag word. The negative, zero, overflow and borrow flags are recomputed from the sized difference. The extend flag is passed through unchanged from its input. Only the operand bits inside the selected size take part; higher bits have no influence.

Top module: `cmp_flag_unit`

## Requirements
- R1: The flag output `ccr_o` is registered: it reflects the inputs sampled at the previous rising clock edge, and a synchronous active-high `rst` clears it to 5'b00000.
- R2: `ccr_o[4]` (extend) equals the value `x_i` had at the previous edge in every mode and size; the other four flags are always recomputed.
- R3: `ccr_o[3]` (negative) equals the most significant bit of the sized difference destination minus source.
- R4: `ccr_o[2]` (zero) is 1 exactly when every bit of the sized difference is 0.
- R5: `ccr_o[0]` (borrow) is 1 exactly when the sized source, read as unsigned, exceeds the sized destination.
- R6: `ccr_o[1]` (overflow) is 1 exactly when the sized operands have different sign bits and the sign of the sized difference differs from the sign of the sized destination.
- R7: `size_i` selects the operand size: 2'b00 uses bits 7:0, 2'b01 uses bits 15:0, 2'b10 and 2'b11 use bits 31:0. Operand bits above the selected size do not change any flag.
- R8: When `test_i` is 1 the source operand is treated as zero, whatever `src_i` holds, so overflow and borrow are 0 and negative and zero describe the sized destination.
- R9: A byte compare of destination 0xC0 with source 0x25 yields negative=1, zero=0, overflow=0, borrow=0 (unsigned higher, signed lower).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dst_i | input | 32 | Destination operand (minuend) |
| src_i | input | 32 | Source operand (subtrahend), ignored in test mode |
| size_i | input | 2 | Operand size code: 00 byte, 01 word, 10/11 long |
| test_i | input | 1 | 1 selects test against zero, 0 selects compare |
| x_i | input | 1 | Current extend flag, passed through |
| ccr_o | output | 5 | Flags {X, N, Z, V, C} |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath with three size lanes. With these values the byte, word and long lanes and both long encodings can all be reached from the ports. Directed vectors place sign and borrow boundaries at each lane width and fill the bits above the selected size with set bits. Random vectors with random sizes and modes are then compared on every clock against a behavioural model built on integer arithmetic.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_WORD     = 2'b01,
        SZ_LONG     = 2'b10,
        SZ_LONG_ALT = 2'b11
    } op_size_e;

    // Flag word layout, most significant first: X N Z V C
    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } arith_flags_t;

    localparam int ARITH_W = $bits(arith_flags_t);
    localparam int BASE_LANE_W = 8;

    function automatic int lane_width(input int idx);
        return BASE_LANE_W << idx;
    endfunction

    function automatic int lane_index(input op_size_e sz);
        case (sz)
            SZ_BYTE: return 0;
            SZ_WORD: return 1;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/cf_operand_gate.sv
module cf_operand_gate
    #(parameter int DATA_W = 32)
(
    input  logic [DATA_W-1:0] src_i,
    input  logic              test_i,
    output logic [DATA_W-1:0] src_eff_o
);
    always_comb begin
        src_eff_o = test_i ? '0 : src_i;
    end
endmodule

// File: rtl/cf_lane_sub.sv
module cf_lane_sub
    import cmpflag_pkg::*;
    #(parameter int W = 8)
(
    input  logic [W-1:0]  d_i,
    input  logic [W-1:0]  s_i,
    output arith_flags_t  flags_o
);
    logic [W:0] diff_ext;
    logic       d_sign;
    logic       s_sign;
    logic       r_sign;

    always_comb begin
        diff_ext   = {1'b0, d_i} - {1'b0, s_i};
        d_sign     = d_i[W-1];
        s_sign     = s_i[W-1];
        r_sign     = diff_ext[W-1];
        flags_o.n  = r_sign;
        flags_o.z  = (diff_ext[W-1:0] == '0);
        flags_o.v  = (d_sign ^ s_sign) & (r_sign ^ d_sign);
        flags_o.c  = diff_ext[W];
    end
endmodule

// File: rtl/cf_lane_bank.sv
module cf_lane_bank
    import cmpflag_pkg::*;
    #(parameter int DATA_W = 32,
      parameter int LANES  = 3)
(
    input  logic [DATA_W-1:0]        dst_i,
    input  logic [DATA_W-1:0]        src_i,
    output logic [LANES*ARITH_W-1:0] lane_flags_o
);
    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam int LW = lane_width(gi);
        arith_flags_t lf;
        cf_lane_sub #(.W(LW)) u_sub (
            .d_i     (dst_i[LW-1:0]),
            .s_i     (src_i[LW-1:0]),
            .flags_o (lf)
        );
        assign lane_flags_o[gi*ARITH_W +: ARITH_W] = lf;
    end
endmodule

// File: rtl/cf_flag_select.sv
module cf_flag_select
    import cmpflag_pkg::*;
    #(parameter int LANES = 3)
(
    input  logic [LANES*ARITH_W-1:0] lane_flags_i,
    input  op_size_e                 size_i,
    input  logic                     x_i,
    output ccr_t                     ccr_o
);
    arith_flags_t picked;

    always_comb begin
        picked = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_index(size_i) == i) begin
                picked = lane_flags_i[i*ARITH_W +: ARITH_W];
            end
        end
        ccr_o.x = x_i;
        ccr_o.n = picked.n;
        ccr_o.z = picked.z;
        ccr_o.v = picked.v;
        ccr_o.c = picked.c;
    end
endmodule

// File: rtl/cmp_flag_unit.sv
module cmp_flag_unit
    import cmpflag_pkg::*;
    #(parameter int DATA_W = 32,
      parameter int LANES  = 3)
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] dst_i,
    input  logic [DATA_W-1:0] src_i,
    input  logic [1:0]        size_i,
    input  logic              test_i,
    input  logic              x_i,
    output logic [4:0]        ccr_o
);
    logic [DATA_W-1:0]        src_eff;
    logic [LANES*ARITH_W-1:0] lane_flags;
    ccr_t                     ccr_next;
    ccr_t                     ccr_q;

    cf_operand_gate #(.DATA_W(DATA_W)) u_gate (
        .src_i     (src_i),
        .test_i    (test_i),
        .src_eff_o (src_eff)
    );

    cf_lane_bank #(.DATA_W(DATA_W), .LANES(LANES)) u_bank (
        .dst_i        (dst_i),
        .src_i        (src_eff),
        .lane_flags_o (lane_flags)
    );

    cf_flag_select #(.LANES(LANES)) u_sel (
        .lane_flags_i (lane_flags),
        .size_i       (op_size_e'(size_i)),
        .x_i          (x_i),
        .ccr_o        (ccr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ccr_q <= '0;
        end else begin
            ccr_q <= ccr_next;
        end
    end

    assign ccr_o = ccr_q;

    // R2: extend flag follows its input by one cycle
    a_r2_x_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ccr_o[4] == $past(x_i)));

    // R8: test mode never reports overflow or borrow
    a_r8_test_no_vc: assert property (@(posedge clk) disable iff (rst)
        test_i |=> (ccr_o[1] == 1'b0 && ccr_o[0] == 1'b0));

    // R4: equal long operands in compare mode give zero and no borrow
    a_r4_equal_zero: assert property (@(posedge clk) disable iff (rst)
        (!test_i && size_i[1] && dst_i == src_i) |=> (ccr_o[2] && !ccr_o[0]));

    // R5: long unsigned source above destination raises borrow
    a_r5_long_borrow: assert property (@(posedge clk) disable iff (rst)
        (!test_i && size_i[1] && src_i > dst_i) |=> ccr_o[0]);

    // R7: equal low bytes give zero at byte size regardless of upper bits
    a_r7_byte_equal: assert property (@(posedge clk) disable iff (rst)
        (!test_i && size_i == 2'b00 && dst_i[7:0] == src_i[7:0]) |=> ccr_o[2]);
endmodule

// File: tb/tb_cmp_flag_unit.sv
module tb_cmp_flag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] dst = '0;
    logic [31:0] src = '0;
    logic [1:0]  size = '0;
    logic        test = 1'b0;
    logic        xin = 1'b0;
    logic [4:0]  ccr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_flag_unit dut (
        .clk(clk), .rst(rst), .dst_i(dst), .src_i(src),
        .size_i(size), .test_i(test), .x_i(xin), .ccr_o(ccr)
    );

    function automatic logic [4:0] model(input longint unsigned d_in,
                                         input longint unsigned s_in,
                                         input int sz, input bit tm, input bit x);
        int w;
        longint unsigned mask, d, s, r;
        bit n, z, v, c, ds, ss;
        w    = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        mask = (64'd1 << w) - 1;
        d    = d_in & mask;
        s    = tm ? 0 : (s_in & mask);
        r    = (d - s) & mask;
        n    = r[w-1];
        z    = (r == 0);
        c    = (s > d);
        ds   = d[w-1];
        ss   = s[w-1];
        v    = (ds != ss) && (n != ds);
        return {x, n, z, v, c};
    endfunction

    task automatic check(input string tag, input logic [4:0] exp);
        checks++;
        if (ccr !== exp) begin
            errors++;
            $display("FAIL %s: ccr=%b expected=%b", tag, ccr, exp);
        end
    endtask

    // called at a negedge: drive, wait one cycle, compare
    task automatic vec(input logic [31:0] d, input logic [31:0] s, input int sz,
                       input bit tm, input bit x, input string tag);
        logic [4:0] e;
        dst = d; src = s; size = sz[1:0]; test = tm; xin = x;
        e = model(d, s, sz, tm, x);
        @(negedge clk);
        check(tag, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: ccr=%b expected=finish", ccr);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        dst = 32'hFFFF_FFFF; src = 32'h1; xin = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset clears flags", 5'b00000);
        rst = 1'b0;

        // R9: worked byte example
        vec(32'h0000_00C0, 32'h0000_0025, 0, 0, 0, "R9 byte C0-25");
        vec(32'hFFFF_FFC0, 32'hABCD_EF25, 0, 0, 1, "R9 R7 upper bits ignored");
        // R2: X pass-through both polarities, all sizes
        vec(32'h1234_5678, 32'h1234_5678, 2, 0, 1, "R2 R4 long equal X=1");
        vec(32'h1234_5678, 32'h1234_5678, 1, 0, 0, "R2 word equal X=0");
        // R5: borrow at each width
        vec(32'h0000_0001, 32'h0000_0002, 0, 0, 0, "R5 byte borrow");
        vec(32'hFFFF_0001, 32'h0000_0002, 1, 0, 0, "R5 word borrow");
        vec(32'h0000_0001, 32'h0000_0002, 3, 0, 1, "R5 long borrow alt code");
        // R6: overflow at sign boundaries
        vec(32'h0000_0080, 32'h0000_0001, 0, 0, 0, "R6 byte 80-01");
        vec(32'h0000_7FFF, 32'h0000_FFFF, 1, 0, 0, "R6 word 7FFF-FFFF");
        vec(32'h8000_0000, 32'h0000_0001, 2, 0, 0, "R6 long min-1");
        vec(32'h7FFF_FFFF, 32'hFFFF_FFFF, 2, 0, 1, "R6 long max-minus1");
        // R3: negative without borrow
        vec(32'h0000_00F0, 32'h0000_0010, 0, 0, 0, "R3 byte negative");
        vec(32'h9000_0000, 32'h1000_0000, 2, 0, 0, "R3 long negative");
        // R7: size encoding and masked upper bits
        vec(32'h0001_0000, 32'h0000_0000, 1, 0, 0, "R7 word ignores bit16");
        vec(32'h0001_0000, 32'h0000_0000, 2, 0, 0, "R7 long sees bit16");
        vec(32'h0001_0000, 32'h0000_0000, 3, 0, 0, "R7 alt long sees bit16");
        // R8: test mode ignores source
        vec(32'h0000_0000, 32'hFFFF_FFFF, 2, 1, 1, "R8 test zero");
        vec(32'h0000_0080, 32'h0000_0001, 0, 1, 0, "R8 test byte negative");
        vec(32'h0000_8000, 32'h7FFF_FFFF, 1, 1, 1, "R8 test word negative");
        vec(32'h0000_0100, 32'hFFFF_FFFF, 0, 1, 0, "R8 R7 test byte zero");
        // R4: zero flag at each size
        vec(32'hAA00_0000, 32'h5500_0000, 1, 0, 0, "R4 word zero");
        vec(32'h0000_0001, 32'h0000_0001, 0, 0, 1, "R4 byte zero");

        // random sweep
        for (int i = 0; i < 400; i++) begin
            vec($urandom, ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom,
                $urandom_range(0, 3), ($urandom_range(0, 4) == 0), $urandom_range(0, 1),
                "R2 R3 R4 R5 R6 R7 R8 random");
        end

        // R1: reset mid-run clears registered flags
        dst = 32'h0; src = 32'h1; size = 2'b00; xin = 1'b1; rst = 1'b1;
        @(negedge clk);
        check("R1 reset mid-run", 5'b00000);
        rst = 1'b0;
        vec(32'h0000_0000, 32'h0000_0001, 0, 0, 1, "R1 R5 after reset");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule